// File: doc/BRIEF.md
# UART Host-Side Ready Signal Controller

This block produces the two active-low handshake outputs that a UART presents to its host: one says receive data is waiting (`rx_ready_n`) and one says the transmitter can accept data (`tx_ready_n`). A host processor or a block-transfer engine watches these pins to decide when to move bytes. The block does not store data. It tracks the occupancy of a receive queue and a transmit queue from push and pop strobes. Each queue holds `DEPTH` (32) bytes when queueing is on and a single holding byte when queueing is off.

Two configuration bits select one of three output modes: `fifo_on` and `burst_mode`. The modes are MODE_HOLD (queueing off, single holding register), MODE_CHAR (queueing on, one character at a time) and MODE_BLOCK (queueing on, block transfers). In MODE_BLOCK the receive output comes from a two-state latch machine. RXL_IDLE is the state with the output released. RXL_ARMED is the state with the output asserted. The transition RXL_IDLE→RXL_ARMED ("arm") fires when the receive fill reaches the selected trigger level, or when a receive timeout pulse arrives while the queue holds data. The transition RXL_ARMED→RXL_IDLE ("drain") fires only when the queue becomes empty or block mode is left. The latch never leaves RXL_IDLE outside block mode.

Top module: `uart_ready_ctrl`

## Requirements
- R1: After reset both queues are empty, `rx_ready_n` is 1 and `tx_ready_n` is 0.
- R2: In MODE_HOLD (`fifo_on`=0), `rx_ready_n` is 0 while the receive holding byte is present and 1 otherwise. A second receive push while the byte is held is ignored, so a single pop releases the output.
- R3: In MODE_HOLD, `tx_ready_n` is 1 while the transmit holding byte is present and 0 when it is empty. An extra push while occupied is ignored.
- R4: In MODE_CHAR (`fifo_on`=1, `burst_mode`=0), `rx_ready_n` is 0 whenever the receive queue holds one or more bytes and 1 when it is empty.
- R5: In MODE_CHAR, `tx_ready_n` is 0 only while the transmit queue is completely empty.
- R6: In MODE_BLOCK (`fifo_on`=1, `burst_mode`=1), `rx_ready_n` falls at the clock edge where the receive fill reaches the trigger level. `rx_trig_sel` selects the level: 0→8, 1→16, 2→24, 3→28 bytes.
- R7: In MODE_BLOCK, a `rx_timeout` pulse asserts `rx_ready_n` below the trigger level if the receive queue is not empty. A pulse on an empty queue is ignored.
- R8: In MODE_BLOCK, once asserted, `rx_ready_n` stays 0 as the fill drops below the trigger level and returns to 1 only when the receive queue becomes empty.
- R9: In MODE_BLOCK, `tx_ready_n` is 0 while the transmit queue has a free slot and 1 when it holds 32 bytes. A push to a full queue is ignored.
- R10: A push and a pop in the same cycle leave a fill count unchanged. A pop from an empty queue is ignored.
- R11: Mode bits take effect at the next clock edge. Leaving block mode returns the latch to RXL_IDLE. A change of `fifo_on` empties both queue counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_on | input | 1 | Queueing enable |
| burst_mode | input | 1 | Block-transfer mode select |
| rx_trig_sel | input | 2 | Receive trigger level select |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_push | input | 1 | Byte written into receive queue |
| rx_pop | input | 1 | Byte read from receive queue |
| tx_push | input | 1 | Byte written into transmit queue |
| tx_pop | input | 1 | Byte removed by transmitter |
| rx_ready_n | output | 1 | Receive data available, active low |
| tx_ready_n | output | 1 | Transmit space available, active low |

## Verification
The hardest situations to reach are the ones that need deep fill. Examples are a transmit queue at exactly 32 bytes that receives one more push, and a receive latch held through a long drain from 28 bytes down to one. The bench reaches them by pushing strobe runs sized from each trigger level. It checks one byte below the level, at the level, at one remaining byte and at empty. Mode switches are made with data still queued, which separates the latch-clearing and count-clearing rules from the ordinary fill behaviour.

// File: rtl/uart_ready_pkg.sv
package uart_ready_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_CHAR  = 2'd1,
        MODE_BLOCK = 2'd2
    } rdy_mode_e;

    typedef enum logic {
        RXL_IDLE  = 1'b0,
        RXL_ARMED = 1'b1
    } rx_latch_e;

    // Trigger level in bytes: quarter steps of the depth, the top code
    // sitting one eighth below full.
    function automatic int unsigned trig_bytes(input logic [1:0] sel,
                                               input int unsigned depth);
        int unsigned lvl;
        if (sel == 2'd3) lvl = depth - depth / 8;
        else             lvl = (depth / 4) * (int'(sel) + 1);
        return lvl;
    endfunction

endpackage

// File: rtl/ready_fill_tracker.sv
module ready_fill_tracker #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          hold_only,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt
);

    logic [CW-1:0] cap;
    logic          has_room;
    logic          has_data;

    assign cap      = hold_only ? CW'(1) : CW'(DEPTH);
    assign has_room = (cnt_q < cap);
    assign has_data = (cnt_q != '0);

    always_comb begin
        cnt_nxt = cnt_q;
        if (clear) begin
            cnt_nxt = '0;
        end else if (push && pop) begin
            cnt_nxt = cnt_q;
        end else if (push && has_room) begin
            cnt_nxt = cnt_q + CW'(1);
        end else if (pop && has_data) begin
            cnt_nxt = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/rx_latch_fsm.sv
module rx_latch_fsm
    import uart_ready_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_act_nxt,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] trig_lvl,
    input  logic          timeout,
    output logic          armed
);

    rx_latch_e state_q;
    rx_latch_e state_d;
    logic      nonempty;

    assign nonempty = (cnt_nxt != '0);

    always_ff @(posedge clk) begin
        if (rst) state_q <= RXL_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXL_IDLE: begin
                if (blk_act_nxt && nonempty && ((cnt_nxt >= trig_lvl) || timeout))
                    state_d = RXL_ARMED;
            end
            RXL_ARMED: begin
                if (!blk_act_nxt || !nonempty)
                    state_d = RXL_IDLE;
            end
            default: state_d = RXL_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == RXL_ARMED);
    end

endmodule

// File: rtl/uart_ready_ctrl.sv
module uart_ready_ctrl
    import uart_ready_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_on,
    input  logic       burst_mode,
    input  logic [1:0] rx_trig_sel,
    input  logic       rx_timeout,
    input  logic       rx_push,
    input  logic       rx_pop,
    input  logic       tx_push,
    input  logic       tx_pop,
    output logic       rx_ready_n,
    output logic       tx_ready_n
);

    logic          fifo_on_q;
    logic          burst_q;
    rdy_mode_e     mode;
    logic          en_change;
    logic [CW-1:0] rx_cnt_q, rx_cnt_nxt;
    logic [CW-1:0] tx_cnt_q, tx_cnt_nxt;
    logic [CW-1:0] trig_lvl;
    logic          rx_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on_q <= 1'b0;
            burst_q   <= 1'b0;
        end else begin
            fifo_on_q <= fifo_on;
            burst_q   <= burst_mode;
        end
    end

    always_comb begin
        if (!fifo_on_q)   mode = MODE_HOLD;
        else if (burst_q) mode = MODE_BLOCK;
        else              mode = MODE_CHAR;
    end

    assign en_change = (fifo_on != fifo_on_q);
    assign trig_lvl  = CW'(trig_bytes(rx_trig_sel, DEPTH));

    ready_fill_tracker #(.DEPTH(DEPTH)) u_rx_fill (
        .clk      (clk),
        .rst      (rst),
        .clear    (en_change),
        .hold_only(!fifo_on_q),
        .push     (rx_push),
        .pop      (rx_pop),
        .cnt_q    (rx_cnt_q),
        .cnt_nxt  (rx_cnt_nxt)
    );

    ready_fill_tracker #(.DEPTH(DEPTH)) u_tx_fill (
        .clk      (clk),
        .rst      (rst),
        .clear    (en_change),
        .hold_only(!fifo_on_q),
        .push     (tx_push),
        .pop      (tx_pop),
        .cnt_q    (tx_cnt_q),
        .cnt_nxt  (tx_cnt_nxt)
    );

    rx_latch_fsm #(.CW(CW)) u_rx_latch (
        .clk        (clk),
        .rst        (rst),
        .blk_act_nxt(fifo_on && burst_mode),
        .cnt_nxt    (rx_cnt_nxt),
        .trig_lvl   (trig_lvl),
        .timeout    (rx_timeout),
        .armed      (rx_armed)
    );

    always_comb begin
        rx_ready_n = 1'b1;
        tx_ready_n = 1'b0;
        unique case (mode)
            MODE_HOLD, MODE_CHAR: begin
                rx_ready_n = (rx_cnt_q == '0);
                tx_ready_n = (tx_cnt_q != '0);
            end
            MODE_BLOCK: begin
                rx_ready_n = !rx_armed;
                tx_ready_n = (tx_cnt_q == CW'(DEPTH));
            end
            default: begin
                rx_ready_n = 1'b1;
                tx_ready_n = 1'b0;
            end
        endcase
    end

    logic unused_nxt;
    assign unused_nxt = ^tx_cnt_nxt;

endmodule

// File: rtl/uart_ready_ctrl_chk.sv
module uart_ready_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       fifo_on,
    input logic       burst_mode,
    input logic [1:0] rx_trig_sel,
    input logic       rx_timeout,
    input logic       rx_push,
    input logic       rx_pop,
    input logic       tx_push,
    input logic       tx_pop,
    input logic       rx_ready_n,
    input logic       tx_ready_n
);

    logic blk_now, char_now;
    assign blk_now  = fifo_on && burst_mode;
    assign char_now = fifo_on && !burst_mode;

    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        rst |=> (rx_ready_n && !tx_ready_n));

    // R8
    blk_rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_now && $past(blk_now) && !rx_ready_n && !rx_pop) |=> !rx_ready_n);

    // R9
    blk_tx_full_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_now && $past(blk_now) && tx_ready_n && !tx_pop) |=> tx_ready_n);

    // R5
    char_tx_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (char_now && $past(char_now) && tx_push && !tx_pop) |=> tx_ready_n);

    // R4
    char_rx_avail_chk: assert property (@(posedge clk) disable iff (rst)
        (char_now && $past(char_now) && rx_push && !rx_pop) |=> !rx_ready_n);

    // R10
    push_pop_same_chk: assert property (@(posedge clk) disable iff (rst)
        (char_now && $past(char_now) && rx_push && rx_pop) |=> $stable(rx_ready_n));

    logic unused_sig;
    assign unused_sig = ^{rx_trig_sel, rx_timeout};

endmodule

bind uart_ready_ctrl uart_ready_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_on    (fifo_on),
    .burst_mode (burst_mode),
    .rx_trig_sel(rx_trig_sel),
    .rx_timeout (rx_timeout),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push),
    .tx_pop     (tx_pop),
    .rx_ready_n (rx_ready_n),
    .tx_ready_n (tx_ready_n)
);

// File: tb/uart_ready_ctrl_bench.sv
module uart_ready_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_on = 1'b0;
    logic       burst_mode = 1'b0;
    logic [1:0] rx_trig_sel = 2'd0;
    logic       rx_timeout = 1'b0;
    logic       rx_push = 1'b0;
    logic       rx_pop = 1'b0;
    logic       tx_push = 1'b0;
    logic       tx_pop = 1'b0;
    logic       rx_ready_n;
    logic       tx_ready_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_ready_ctrl u_uart_ready_ctrl (
        .clk(clk), .rst(rst), .fifo_on(fifo_on), .burst_mode(burst_mode),
        .rx_trig_sel(rx_trig_sel), .rx_timeout(rx_timeout),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_ready_n(rx_ready_n), .tx_ready_n(tx_ready_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic rx_in(input int n);
        for (int i = 0; i < n; i++) begin rx_push = 1'b1; step(); end
        rx_push = 1'b0;
    endtask

    task automatic rx_out(input int n);
        for (int i = 0; i < n; i++) begin rx_pop = 1'b1; step(); end
        rx_pop = 1'b0;
    endtask

    task automatic tx_in(input int n);
        for (int i = 0; i < n; i++) begin tx_push = 1'b1; step(); end
        tx_push = 1'b0;
    endtask

    task automatic tx_out(input int n);
        for (int i = 0; i < n; i++) begin tx_pop = 1'b1; step(); end
        tx_pop = 1'b0;
    endtask

    task automatic set_mode(input logic en, input logic blk);
        fifo_on = en; burst_mode = blk;
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
        check(rx_ready_n, 1'b1, "R1 rx_ready_n after reset");
        check(tx_ready_n, 1'b0, "R1 tx_ready_n after reset");
    endtask

    task automatic t_hold();
        set_mode(1'b0, 1'b0);
        rx_in(1);
        check(rx_ready_n, 1'b0, "R2 holding byte present");
        rx_in(1);
        rx_out(1);
        check(rx_ready_n, 1'b1, "R2 extra push ignored, one pop empties");
        tx_in(1);
        check(tx_ready_n, 1'b1, "R3 holding register occupied");
        tx_in(1);
        tx_out(1);
        check(tx_ready_n, 1'b0, "R3 extra push ignored, one pop empties");
    endtask

    task automatic t_char();
        set_mode(1'b1, 1'b0);
        rx_in(3);
        check(rx_ready_n, 1'b0, "R4 three bytes queued");
        rx_out(2);
        check(rx_ready_n, 1'b0, "R4 one byte left");
        rx_out(1);
        check(rx_ready_n, 1'b1, "R4 queue empty");
        rx_out(1);
        rx_in(1);
        check(rx_ready_n, 1'b0, "R10 pop on empty ignored");
        rx_push = 1'b1; rx_pop = 1'b1; step(); rx_push = 1'b0; rx_pop = 1'b0;
        check(rx_ready_n, 1'b0, "R10 push+pop keeps one byte");
        rx_out(1);
        check(rx_ready_n, 1'b1, "R10 count unchanged by push+pop");
        rx_push = 1'b1; rx_pop = 1'b1; step(); rx_push = 1'b0; rx_pop = 1'b0;
        check(rx_ready_n, 1'b1, "R10 push+pop on empty keeps empty");
        tx_in(1);
        check(tx_ready_n, 1'b1, "R5 one byte queued");
        tx_in(4);
        tx_out(4);
        check(tx_ready_n, 1'b1, "R5 one byte still queued");
        tx_out(1);
        check(tx_ready_n, 1'b0, "R5 queue empty");
    endtask

    task automatic t_blk_trig();
        int lvls[4] = '{8, 16, 24, 28};
        set_mode(1'b1, 1'b1);
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            rx_in(lvls[s] - 1);
            check(rx_ready_n, 1'b1, $sformatf("R6 sel %0d one below level", s));
            rx_in(1);
            check(rx_ready_n, 1'b0, $sformatf("R6 sel %0d at level", s));
            rx_out(lvls[s] - 1);
            check(rx_ready_n, 1'b0, $sformatf("R8 sel %0d one byte left", s));
            rx_out(1);
            check(rx_ready_n, 1'b1, $sformatf("R8 sel %0d drained", s));
        end
        rx_trig_sel = 2'd0;
    endtask

    task automatic t_timeout();
        set_mode(1'b1, 1'b1);
        rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
        step();
        check(rx_ready_n, 1'b1, "R7 timeout on empty ignored");
        rx_in(2);
        check(rx_ready_n, 1'b1, "R7 below level before timeout");
        rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
        check(rx_ready_n, 1'b0, "R7 timeout asserts");
        rx_out(1);
        check(rx_ready_n, 1'b0, "R8 held after timeout");
        rx_out(1);
        check(rx_ready_n, 1'b1, "R8 released at empty");
    endtask

    task automatic t_blk_tx();
        set_mode(1'b1, 1'b1);
        tx_in(31);
        check(tx_ready_n, 1'b0, "R9 one free slot");
        tx_in(1);
        check(tx_ready_n, 1'b1, "R9 full");
        tx_in(1);
        tx_out(1);
        check(tx_ready_n, 1'b0, "R9 push at full ignored");
        tx_out(31);
        set_mode(1'b1, 1'b0);
        check(tx_ready_n, 1'b0, "R9 drained to empty");
    endtask

    task automatic t_mode();
        set_mode(1'b1, 1'b1);
        rx_trig_sel = 2'd0;
        rx_in(8);
        check(rx_ready_n, 1'b0, "R6 armed before mode switch");
        set_mode(1'b1, 1'b0);
        rx_out(4);
        set_mode(1'b1, 1'b1);
        check(rx_ready_n, 1'b1, "R11 latch cleared by leaving block mode");
        tx_in(3);
        check(tx_ready_n, 1'b0, "R11 block mode tx with free slots");
        burst_mode = 1'b0;
        #1;
        check(tx_ready_n, 1'b0, "R11 no change before edge");
        step();
        check(tx_ready_n, 1'b1, "R11 char mode after edge");
        set_mode(1'b0, 1'b0);
        check(tx_ready_n, 1'b0, "R11 enable change empties tx");
        check(rx_ready_n, 1'b1, "R11 enable change empties rx");
    endtask

    initial begin
        t_reset();
        t_hold();
        t_char();
        t_blk_trig();
        t_timeout();
        t_blk_tx();
        t_mode();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule